// File: doc/BRIEF.md
# Prescaled Timer Counter with Coherent Byte Read

This block is a 16-bit free-running up-counter for a CPU with an 8-bit data bus. A 3-bit clock select chooses what advances the counter. Seven settings divide the bus clock by a power of two, from 1 to 64. The eighth setting counts rising edges of an external clock pin. That pin is first passed through a two-flop synchronizer, so everything runs on the bus clock and the counter moves on a single-cycle enable pulse.

The CPU reads the count as two bytes. Reading the high byte freezes a copy of the low byte. A later read of the low byte returns that copy, so the two bytes come from the same instant even though the counter keeps running. Repeated high-byte reads leave the frozen copy untouched until the low byte is read. A control register holds the clock select and a self-clearing bit that restarts the count and the divider phase.

Top module: `prescaled_timer`

## Requirements
- R1: After reset, the clock select reads 000, both count bytes read 0x00 and no low-byte copy is pending.
- R2: With select s in 0..6, the count advances once every 2^s bus cycles. Exactly n bus clock edges after the edge that applies a clear, the count equals floor(n / 2^s).
- R3: With select 111, the count advances once per rising edge of `ext_clk`, seen through a two-flop synchronizer. `ext_clk` must stay high and low for at least two bus cycles each. With no such edge, the count holds.
- R4: The register address map is: 0 = control, 1 = count high byte (bits 15:8), 2 = count low byte (bits 7:0), 3 = reads 0x00. In the control register, bits 2:0 are the clock select and bit 7 is the clear bit.
- R5: A high-byte read when no copy is pending stores the current low byte. The next low-byte read returns that stored value, so {high, low} is the count at the high-byte read.
- R6: While a copy is pending, further high-byte reads do not refresh it. Only a low-byte read releases it.
- R7: A low-byte read with no pending copy returns the live low byte.
- R8: Writes to addresses 1, 2 and 3 do not change the count.
- R9: A control write with bit 7 set loads the select from bits 2:0 and clears the counter and the divider phase in the same cycle. Bit 7 always reads as 0.
- R10: The count wraps from 0xFFFF to 0x0000.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bus clock |
| rst | input | 1 | Synchronous active-high reset |
| addr | input | 2 | Register address |
| rd_en | input | 1 | Read strobe, one cycle per access |
| wr_en | input | 1 | Write strobe, one cycle per access |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data for `addr` (combinational) |
| ext_clk | input | 1 | External count clock, asynchronous |

## Verification
The properties assume that `rd_en` and `wr_en` are never high in the same cycle. They also assume that `ext_clk` changes slowly enough for each level to be seen by the synchronizer. The bench drives single-cycle strobes, one per access, and holds `ext_clk` for four bus cycles per phase.

The checks on the frozen low-byte copy compare against the value captured at the high-byte read. The divider checks count bus edges from the clear, so the stimulus always starts each rate test with a clear write.

// File: rtl/tmr_pkg.sv
package tmr_pkg;

    localparam int BUS_W     = 8;
    localparam int CNT_W     = 2 * BUS_W;
    localparam int DIV_W     = 6;
    localparam int SEL_W     = 3;
    localparam int ADDR_W    = 2;
    localparam int CLR_BIT   = 7;

    typedef enum logic [SEL_W-1:0] {
        SEL_DIV1  = 3'd0,
        SEL_DIV2  = 3'd1,
        SEL_DIV4  = 3'd2,
        SEL_DIV8  = 3'd3,
        SEL_DIV16 = 3'd4,
        SEL_DIV32 = 3'd5,
        SEL_DIV64 = 3'd6,
        SEL_EXT   = 3'd7
    } clk_sel_e;

    typedef enum logic [ADDR_W-1:0] {
        REG_CTRL   = 2'd0,
        REG_CNT_HI = 2'd1,
        REG_CNT_LO = 2'd2,
        REG_SPARE  = 2'd3
    } reg_addr_e;

    typedef struct packed {
        logic     clr;
        clk_sel_e sel;
    } ctrl_wr_t;

    typedef struct packed {
        logic rd_hi;
        logic rd_lo;
        logic wr_ctrl;
    } bus_dec_t;

    function automatic ctrl_wr_t unpack_ctrl(input logic [BUS_W-1:0] d);
        ctrl_wr_t c;
        c.clr = d[CLR_BIT];
        c.sel = clk_sel_e'(d[SEL_W-1:0]);
        return c;
    endfunction

    function automatic logic [BUS_W-1:0] pack_ctrl(input clk_sel_e s);
        logic [BUS_W-1:0] d;
        d = '0;
        d[SEL_W-1:0] = s;
        return d;
    endfunction

endpackage

// File: rtl/tmr_ext_edge.sv
module tmr_ext_edge (
    input  logic clk,
    input  logic rst,
    input  logic pin,
    output logic rise
);
    logic meta_q, sync_q, prev_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            meta_q <= 1'b0;
            sync_q <= 1'b0;
            prev_q <= 1'b0;
        end else begin
            meta_q <= pin;
            sync_q <= meta_q;
            prev_q <= sync_q;
        end
    end

    assign rise = sync_q & ~prev_q;
endmodule

// File: rtl/tmr_prescaler.sv
module tmr_prescaler
    import tmr_pkg::*;
#(
    parameter int STAGES = DIV_W
) (
    input  logic     clk,
    input  logic     rst,
    input  logic     clr,
    input  clk_sel_e sel,
    input  logic     ext_rise,
    output logic     tick
);
    logic [STAGES-1:0] div_q;
    logic [STAGES-1:0] mask;

    always_ff @(posedge clk) begin
        if (rst || clr) div_q <= '0;
        else            div_q <= div_q + 1'b1;
    end

    for (genvar i = 0; i < STAGES; i++) begin : g_mask
        assign mask[i] = (sel > SEL_W'(i));
    end

    always_comb begin
        if (sel == SEL_EXT) tick = ext_rise;
        else                tick = ((div_q & mask) == mask);
    end
endmodule

// File: rtl/tmr_read_latch.sv
module tmr_read_latch
    import tmr_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             rd_hi,
    input  logic             rd_lo,
    input  logic [BUS_W-1:0] live_lo,
    output logic [BUS_W-1:0] view_lo,
    output logic [BUS_W-1:0] held_lo,
    output logic             pending
);
    logic [BUS_W-1:0] buf_q;
    logic             pend_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            buf_q  <= '0;
            pend_q <= 1'b0;
        end else if (rd_lo) begin
            pend_q <= 1'b0;
        end else if (rd_hi && !pend_q) begin
            buf_q  <= live_lo;
            pend_q <= 1'b1;
        end
    end

    assign view_lo = pend_q ? buf_q : live_lo;
    assign held_lo = buf_q;
    assign pending = pend_q;
endmodule

// File: rtl/prescaled_timer.sv
module prescaled_timer
    import tmr_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] addr,
    input  logic              rd_en,
    input  logic              wr_en,
    input  logic [BUS_W-1:0]  wdata,
    output logic [BUS_W-1:0]  rdata,
    input  logic              ext_clk
);
    bus_dec_t         dec;
    ctrl_wr_t         wr_fields;
    clk_sel_e         sel_q;
    logic             clr;
    logic             ext_rise;
    logic             tick;
    logic [CNT_W-1:0] cnt_q;
    logic [BUS_W-1:0] lo_view;
    logic [BUS_W-1:0] lo_held;
    logic             lo_pending;
    logic             unused_wbits;

    assign unused_wbits = ^wdata[CLR_BIT-1:SEL_W];

    always_comb begin
        dec.rd_hi   = rd_en && (reg_addr_e'(addr) == REG_CNT_HI);
        dec.rd_lo   = rd_en && (reg_addr_e'(addr) == REG_CNT_LO);
        dec.wr_ctrl = wr_en && (reg_addr_e'(addr) == REG_CTRL);
    end

    assign wr_fields = unpack_ctrl(wdata);
    assign clr       = dec.wr_ctrl && wr_fields.clr;

    always_ff @(posedge clk) begin
        if (rst)              sel_q <= SEL_DIV1;
        else if (dec.wr_ctrl) sel_q <= wr_fields.sel;
    end

    tmr_ext_edge i_ext (
        .clk  (clk),
        .rst  (rst),
        .pin  (ext_clk),
        .rise (ext_rise)
    );

    tmr_prescaler #(.STAGES(DIV_W)) i_div (
        .clk      (clk),
        .rst      (rst),
        .clr      (clr),
        .sel      (sel_q),
        .ext_rise (ext_rise),
        .tick     (tick)
    );

    always_ff @(posedge clk) begin
        if (rst || clr) cnt_q <= '0;
        else if (tick)  cnt_q <= cnt_q + 1'b1;
    end

    tmr_read_latch i_latch (
        .clk     (clk),
        .rst     (rst),
        .rd_hi   (dec.rd_hi),
        .rd_lo   (dec.rd_lo),
        .live_lo (cnt_q[BUS_W-1:0]),
        .view_lo (lo_view),
        .held_lo (lo_held),
        .pending (lo_pending)
    );

    always_comb begin
        case (reg_addr_e'(addr))
            REG_CTRL:   rdata = pack_ctrl(sel_q);
            REG_CNT_HI: rdata = cnt_q[CNT_W-1:BUS_W];
            REG_CNT_LO: rdata = lo_view;
            default:    rdata = '0;
        endcase
    end
endmodule

// File: rtl/prescaled_timer_chk.sv
module prescaled_timer_chk
    import tmr_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic [CNT_W-1:0]  cnt,
    input logic              clr,
    input logic              tick,
    input clk_sel_e          sel,
    input logic              ext_rise,
    input logic              pending,
    input logic [BUS_W-1:0]  held,
    input logic              rd_hi,
    input logic              rd_lo,
    input logic [ADDR_W-1:0] addr,
    input logic [BUS_W-1:0]  rdata
);
    AST_HOLD_NO_TICK: assert property (@(posedge clk) disable iff (rst)
        (!clr && !tick) |=> $stable(cnt)); // R2
    AST_EXT_NO_EDGE: assert property (@(posedge clk) disable iff (rst)
        (sel == SEL_EXT && !ext_rise && !clr) |=> $stable(cnt)); // R3
    AST_CAPTURE: assert property (@(posedge clk) disable iff (rst)
        (rd_hi && !rd_lo && !pending) |=> (pending && held == $past(cnt[BUS_W-1:0]))); // R5
    AST_FROZEN: assert property (@(posedge clk) disable iff (rst)
        (pending && !rd_lo) |=> (pending && $stable(held))); // R6
    AST_RELEASE: assert property (@(posedge clk) disable iff (rst)
        rd_lo |=> !pending); // R6
    AST_CLEARED: assert property (@(posedge clk) disable iff (rst)
        clr |=> (cnt == '0)); // R9
    AST_CLR_READS_ZERO: assert property (@(posedge clk) disable iff (rst)
        (addr == REG_CTRL) |-> (rdata[CLR_BIT] == 1'b0)); // R9
    AST_WRAP: assert property (@(posedge clk) disable iff (rst)
        (cnt == '1 && tick && !clr) |=> (cnt == '0)); // R10
endmodule

bind prescaled_timer prescaled_timer_chk i_chk (
    .clk      (clk),
    .rst      (rst),
    .cnt      (cnt_q),
    .clr      (clr),
    .tick     (tick),
    .sel      (sel_q),
    .ext_rise (ext_rise),
    .pending  (lo_pending),
    .held     (lo_held),
    .rd_hi    (dec.rd_hi),
    .rd_lo    (dec.rd_lo),
    .addr     (addr),
    .rdata    (rdata)
);

// File: tb/test_prescaled_timer.sv
module test_prescaled_timer;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [1:0] addr = 2'd0;
    logic       rd_en = 1'b0;
    logic       wr_en = 1'b0;
    logic [7:0] wdata = 8'h00;
    logic [7:0] rdata;
    logic       ext_clk = 1'b0;

    int unsigned vec = 0;
    int unsigned bad = 0;
    int          j = 0;
    bit          done = 0;

    always #2 clk = ~clk;

    prescaled_timer i_prescaled_timer (
        .clk(clk), .rst(rst), .addr(addr), .rd_en(rd_en), .wr_en(wr_en),
        .wdata(wdata), .rdata(rdata), .ext_clk(ext_clk)
    );

    task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
        vec++;
        if (got !== exp) begin
            bad++;
            $display("FAIL %s: actual %0h expected %0h", req, got, exp);
        end
    endtask

    task automatic bus_write(input logic [1:0] a, input logic [7:0] d);
        addr = a; wdata = d; wr_en = 1'b1;
        @(negedge clk);
        wr_en = 1'b0;
        j++;
    endtask

    task automatic bus_read(input logic [1:0] a, output logic [7:0] d);
        addr = a; rd_en = 1'b1;
        #1 d = rdata;
        @(negedge clk);
        rd_en = 1'b0;
        j++;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
        j += n;
    endtask

    task automatic clear_sel(input int s);
        bus_write(2'd0, 8'h80 | 8'(s));
        j = 0;
    endtask

    task automatic read16(output logic [15:0] v);
        logic [7:0] h, l;
        bus_read(2'd1, h);
        bus_read(2'd2, l);
        v = {h, l};
    endtask

    function automatic logic [31:0] expect_cnt(input int s);
        return 32'((j >> s) & 16'hFFFF);
    endfunction

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            vec++; bad++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("== %0d vectors applied, %0d miscompares ==", vec, bad);
            $finish;
        end
    end

    initial begin
        logic [7:0]  d;
        logic [15:0] v;
        logic [31:0] e;
        int          waits[3];
        waits = '{5, 300, 1000};

        // R1: reset state, sampled while reset is held
        repeat (3) @(negedge clk);
        addr = 2'd0; #1 chk("R1 ctrl", rdata, 8'h00);
        addr = 2'd1; #1 chk("R1 high", rdata, 8'h00);
        addr = 2'd2; #1 chk("R1 low", rdata, 8'h00);
        @(negedge clk);
        rst = 1'b0;

        // R2 and R5: rate sweep over every divided select
        for (int s = 0; s < 7; s++) begin
            for (int w = 0; w < 3; w++) begin
                clear_sel(s);
                idle(waits[w]);
                e = expect_cnt(s);
                read16(v);
                chk($sformatf("R2 R5 sel=%0d n=%0d", s, waits[w]), 32'(v), e);
            end
            bus_read(2'd0, d);
            chk($sformatf("R4 R9 ctrl sel=%0d", s), 32'(d), 32'(s)); // R9 bit 7 reads 0
        end

        // R4: spare address reads zero
        bus_read(2'd3, d);
        chk("R4 spare", 32'(d), 32'h0);

        // R6: repeated high reads keep the frozen low byte
        clear_sel(0);
        idle(10);
        e = expect_cnt(0);
        bus_read(2'd1, d);
        idle(5);
        bus_read(2'd1, d);
        chk("R6 second high", 32'(d), 32'h0);
        bus_read(2'd2, d);
        chk("R6 frozen low", 32'(d), e & 32'hFF);

        // R7: low read with nothing pending is live
        e = expect_cnt(0);
        bus_read(2'd2, d);
        chk("R7 live low", 32'(d), e & 32'hFF);

        // R8: writes to count registers are ignored
        clear_sel(2);
        idle(40);
        bus_write(2'd1, 8'hFF);
        bus_write(2'd2, 8'hFF);
        bus_write(2'd3, 8'hAA);
        e = expect_cnt(2);
        read16(v);
        chk("R8 count after writes", 32'(v), e);

        // R9: clear restarts counting in phase with sel 3
        clear_sel(3);
        idle(7);
        e = expect_cnt(3);
        read16(v);
        chk("R9 before first tick", 32'(v), e);
        idle(1);
        e = expect_cnt(3);
        read16(v);
        chk("R9 first tick", 32'(v), e);

        // R3: external clock edges
        clear_sel(7);
        idle(6);
        read16(v);
        chk("R3 no edges", 32'(v), 32'h0);
        for (int k = 0; k < 20; k++) begin
            ext_clk = 1'b1; idle(4);
            ext_clk = 1'b0; idle(4);
        end
        idle(4);
        read16(v);
        chk("R3 twenty edges", 32'(v), 32'd20);

        // R10: wrap from 0xFFFF to 0x0000
        clear_sel(0);
        idle(65536 + 3);
        e = expect_cnt(0);
        read16(v);
        chk("R10 wrap", 32'(v), e);

        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", vec, bad);
        $finish;
    end
endmodule